// File: doc/BRIEF.md
# Multi-Slot Conversion Sequencer

This block orders the conversions of an analog front end across a bank of sixteen result slots. Every slot has a control entry with an input channel number and a last-of-run marker. The two are given to the block as flat vectors. A run starts on a rising edge of the trigger input, and only while the enable input is high. The block then steps through one or more slots, in one of four modes. The mode, the first slot and the chaining flag are captured when a run starts.

For the slot being worked on, the block presents the slot index and its channel number, so that an external multiplexer can select the input. It waits for a sample-done strobe and then for a conversion-done strobe that comes with the result. On conversion-done it stores the result in the slot, sets that slot's completion flag, and moves on. Reading a slot through the read port with the read strobe clears its flag. Writing a slot whose flag is still set raises a sticky overflow indicator.

Top module: `conv_seq`

## Requirements
- R1: Mode 0 converts the start slot once and returns to idle after the conversion-done strobe, whatever the chaining flag holds.
- R2: A run begins at the slot given by the 4-bit start slot input, and slot_o shows that slot while it is sampled.
- R3: Mode 1 steps upward from the start slot one slot per conversion. It returns to idle after converting a slot whose bit in slot_eos_i (bit k for slot k) is set.
- R4: The slot index wraps from 15 to 0 when no end marker has been met.
- R5: With the chaining flag low, each conversion after the first waits for a new rising trigger edge. With it high, the next sample phase begins in the cycle after conversion-done.
- R6: busy_o is high from the accepted trigger until the run ends, including the waits for triggers between conversions, and low in idle.
- R7: A trigger edge seen while en_i is low and the block is idle starts nothing.
- R8: Conversion-done stores result_i in the current slot and sets bit k of done_flags_o for slot k. A cycle with rd_en_i high clears the flag of slot rd_addr_i. rd_data_o always shows the stored result of slot rd_addr_i.
- R9: ovf_o goes high and stays high until reset when a slot is written while its flag is set and is not being read in that cycle.
- R10: Mode 2 converts the start slot again and again. If en_i is low when a conversion completes, the run ends.
- R11: Mode 3 goes back to the start slot after the marked slot. If en_i is low when the marked slot completes, the run ends.
- R12: chan_o gives the channel field of the current slot, taken from bits 4k+3 down to 4k of slot_chan_i for slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Conversion enable |
| mode_i | input | 2 | Mode: 0 single, 1 sequence, 2 repeat single, 3 repeat sequence |
| start_slot_i | input | 4 | First slot of a run |
| chain_i | input | 1 | Chain conversions without new trigger edges |
| trig_i | input | 1 | Trigger; the rising edge is used |
| sample_done_i | input | 1 | Sample phase finished strobe |
| conv_done_i | input | 1 | Conversion finished strobe, qualifies result_i |
| result_i | input | 12 | Conversion result |
| slot_eos_i | input | 16 | Last-of-run marker per slot |
| slot_chan_i | input | 64 | Channel field per slot, 4 bits each |
| rd_en_i | input | 1 | Read strobe, clears the addressed flag |
| rd_addr_i | input | 4 | Slot to read |
| rd_data_o | output | 12 | Stored result of the addressed slot |
| done_flags_o | output | 16 | Completion flag per slot |
| ovf_o | output | 1 | Sticky overwrite-before-read flag |
| busy_o | output | 1 | Run in progress |
| slot_o | output | 4 | Current slot index |
| chan_o | output | 4 | Channel of the current slot |

## Verification
The assertions assume that sample-done arrives only while the block samples and conversion-done only while it converts. They also assume that mode, start slot and chaining flag settle before the trigger edge that starts a run. The directed tasks drive each strobe for exactly one cycle, at the point the bench's own cycle count puts the block in the matching phase. They hold the trigger low for a full cycle between pulses, so every intended edge is seen. The control inputs change only while the block is idle. en_i is lowered only during a sample phase, to test how repeat modes stop.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SAMP = 2'd2,
    ST_CONV = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    M_SINGLE     = 2'd0,
    M_SEQ        = 2'd1,
    M_REP_SINGLE = 2'd2,
    M_REP_SEQ    = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/trig_edge.sv
module trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import cseq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           mode_i,
  input  logic [SLOT_W-1:0]    start_i,
  input  logic                 chain_i,
  input  logic                 rise_i,
  input  logic                 sample_done_i,
  input  logic                 conv_done_i,
  input  logic [NUM_SLOTS-1:0] eos_i,
  output logic [SLOT_W-1:0]    ptr_o,
  output logic                 busy_o,
  output logic                 wr_o
);
  seq_st_e           st_q, st_d, st_next_conv;
  seq_mode_e         mode_q;
  logic              chain_q;
  logic [SLOT_W-1:0] start_q, ptr_q, ptr_d, ptr_inc;
  logic              launch, last;

  assign launch       = (st_q == ST_IDLE) && en_i && rise_i;
  assign last         = eos_i[ptr_q];
  assign ptr_inc      = (ptr_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + 1'b1;
  assign st_next_conv = chain_q ? ST_SAMP : ST_WAIT;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    unique case (st_q)
      ST_IDLE: if (launch) begin
        st_d  = ST_SAMP;
        ptr_d = start_i;
      end
      ST_WAIT: if (rise_i) st_d = ST_SAMP;
      ST_SAMP: if (sample_done_i) st_d = ST_CONV;
      ST_CONV: if (conv_done_i) begin
        unique case (mode_q)
          M_SINGLE: st_d = ST_IDLE;
          M_SEQ: begin
            if (last) st_d = ST_IDLE;
            else begin
              ptr_d = ptr_inc;
              st_d  = st_next_conv;
            end
          end
          M_REP_SINGLE: st_d = en_i ? st_next_conv : ST_IDLE;
          M_REP_SEQ: begin
            if (!last) begin
              ptr_d = ptr_inc;
              st_d  = st_next_conv;
            end else if (en_i) begin
              ptr_d = start_q;
              st_d  = st_next_conv;
            end else begin
              st_d = ST_IDLE;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      mode_q  <= M_SINGLE;
      chain_q <= 1'b0;
      start_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      if (launch) begin
        mode_q  <= seq_mode_e'(mode_i);
        chain_q <= chain_i;
        start_q <= start_i;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign busy_o = (st_q != ST_IDLE);
  assign wr_o   = (st_q == ST_CONV) && conv_done_i;

  // R7: no start without enable
  p_start_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> (st_q == ST_IDLE));

  // R1: single mode ends after one conversion
  p_single_ends_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mode_q == M_SINGLE) |=> (st_q == ST_IDLE));

  // R3: marked slot ends a one-pass sequence
  p_seq_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mode_q == M_SEQ && last) |=> (st_q == ST_IDLE));

  // R4: unmarked slot advances the pointer with wrap
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && (mode_q == M_SEQ || mode_q == M_REP_SEQ) && !last)
      |=> (ptr_q == SLOT_W'($past(ptr_q) + 1'b1)));

  // R5: chained runs go straight to sampling, unchained runs wait
  p_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mode_q != M_SINGLE && en_i && !last && chain_q) |=> (st_q == ST_SAMP));
  p_unchained_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mode_q != M_SINGLE && en_i && !last && !chain_q) |=> (st_q == ST_WAIT));

  // R11: repeat sequence returns to start slot
  p_rep_return_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mode_q == M_REP_SEQ && last && en_i) |=> (ptr_q == start_q));
endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W     = 12,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [SLOT_W-1:0]    wr_addr_i,
  input  logic [RES_W-1:0]     wr_data_i,
  input  logic                 rd_en_i,
  input  logic [SLOT_W-1:0]    rd_addr_i,
  output logic [RES_W-1:0]     rd_data_o,
  output logic [NUM_SLOTS-1:0] flags_o,
  output logic                 ovf_o
);
  logic [RES_W-1:0]     mem_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] flag_q;
  logic                 ovf_q;
  logic                 rd_hit;

  assign rd_hit = rd_en_i && (rd_addr_i == wr_addr_i);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[k]  <= '0;
        flag_q[k] <= 1'b0;
      end else if (wr_i && wr_addr_i == SLOT_W'(k)) begin
        mem_q[k]  <= wr_data_i;
        flag_q[k] <= 1'b1;
      end else if (rd_en_i && rd_addr_i == SLOT_W'(k)) begin
        flag_q[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (wr_i && flag_q[wr_addr_i] && !rd_hit) ovf_q <= 1'b1;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign flags_o   = flag_q;
  assign ovf_o     = ovf_q;

  // R8: write sets the slot flag
  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> flag_q[$past(wr_addr_i)]);

  // R9: overwrite of unread slot raises overflow, which then stays
  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && flag_q[wr_addr_i] && !rd_hit) |=> ovf_o);
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W     = 12,
  parameter int CH_W      = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [1:0]                mode_i,
  input  logic [SLOT_W-1:0]         start_slot_i,
  input  logic                      chain_i,
  input  logic                      trig_i,
  input  logic                      sample_done_i,
  input  logic                      conv_done_i,
  input  logic [RES_W-1:0]          result_i,
  input  logic [NUM_SLOTS-1:0]      slot_eos_i,
  input  logic [NUM_SLOTS*CH_W-1:0] slot_chan_i,
  input  logic                      rd_en_i,
  input  logic [SLOT_W-1:0]         rd_addr_i,
  output logic [RES_W-1:0]          rd_data_o,
  output logic [NUM_SLOTS-1:0]      done_flags_o,
  output logic                      ovf_o,
  output logic                      busy_o,
  output logic [SLOT_W-1:0]         slot_o,
  output logic [CH_W-1:0]           chan_o
);
  logic              rise, wr;
  logic [SLOT_W-1:0] ptr;
  logic [CH_W-1:0]   chan_arr [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chan
    assign chan_arr[k] = slot_chan_i[k*CH_W +: CH_W];
  end

  trig_edge i_trig_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  seq_fsm #(.NUM_SLOTS(NUM_SLOTS)) i_seq_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .mode_i        (mode_i),
    .start_i       (start_slot_i),
    .chain_i       (chain_i),
    .rise_i        (rise),
    .sample_done_i (sample_done_i),
    .conv_done_i   (conv_done_i),
    .eos_i         (slot_eos_i),
    .ptr_o         (ptr),
    .busy_o        (busy_o),
    .wr_o          (wr)
  );

  result_store #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) i_result_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_addr_i (ptr),
    .wr_data_i (result_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .flags_o   (done_flags_o),
    .ovf_o     (ovf_o)
  );

  assign slot_o = ptr;
  assign chan_o = chan_arr[ptr];

  // R6: busy only after a launch, idle after reset
  p_busy_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i && trig_i));
endmodule

// File: tb/test_conv_seq.sv
module test_conv_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [3:0]  start_slot_i = '0;
  logic        chain_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        sample_done_i = 1'b0;
  logic        conv_done_i = 1'b0;
  logic [11:0] result_i = '0;
  logic [15:0] slot_eos_i = '0;
  logic [63:0] slot_chan_i = '0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic [11:0] rd_data_o;
  logic [15:0] done_flags_o;
  logic        ovf_o, busy_o;
  logic [3:0]  slot_o, chan_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  conv_seq i_conv_seq (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i = 1'b0; trig_i = 1'b0; sample_done_i = 1'b0; conv_done_i = 1'b0;
    rd_en_i = 1'b0; chain_i = 1'b0; mode_i = '0; start_slot_i = '0; slot_eos_i = '0;
    for (int k = 0; k < 16; k++) slot_chan_i[k*4 +: 4] = 4'(k ^ 5);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_conv(input logic [11:0] val);
    sample_done_i = 1'b1;
    @(negedge clk_i);
    sample_done_i = 1'b0;
    conv_done_i = 1'b1;
    result_i = val;
    @(negedge clk_i);
    conv_done_i = 1'b0;
  endtask

  task automatic read_slot(input logic [3:0] a, input logic [11:0] exp, input string req);
    rd_addr_i = a;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic t_reset();
    reset_dut();
    check("R6 busy after reset", busy_o, 0);
    check("R8 flags after reset", done_flags_o, 0);
    check("R9 ovf after reset", ovf_o, 0);
  endtask

  task automatic t_no_enable();
    reset_dut();
    en_i = 1'b0;
    pulse_trig();
    check("R7 busy with en low", busy_o, 0);
    check("R7 flags with en low", done_flags_o, 0);
  endtask

  task automatic t_single();
    reset_dut();
    en_i = 1'b1; mode_i = 2'd0; start_slot_i = 4'd3; chain_i = 1'b1;
    pulse_trig();
    check("R2 slot at sample", slot_o, 3);
    check("R12 channel of slot 3", chan_o, 3 ^ 5);
    check("R6 busy during sample", busy_o, 1);
    do_conv(12'hABC);
    check("R1 idle after single", busy_o, 0);
    check("R8 flag slot 3", done_flags_o, 16'h0008);
    read_slot(4'd3, 12'hABC, "R8 data slot 3");
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check("R8 flag cleared by read", done_flags_o, 0);
    pulse_trig();
    do_conv(12'h123);
    check("R9 no ovf after read", ovf_o, 0);
  endtask

  task automatic t_seq_trig();
    reset_dut();
    en_i = 1'b1; mode_i = 2'd1; start_slot_i = 4'd2; chain_i = 1'b0;
    slot_eos_i = 16'h0010;
    for (int s = 2; s <= 4; s++) begin
      pulse_trig();
      check("R3 slot order", slot_o, s);
      do_conv(12'(s * 16 + 1));
      if (s < 4) begin
        @(negedge clk_i);
        check("R6 busy while waiting", busy_o, 1);
        check("R5 no sample without edge", done_flags_o, 16'((1 << (s + 1)) - 4));
      end
    end
    check("R3 idle after marked slot", busy_o, 0);
    check("R3 flags 2..4", done_flags_o, 16'h001C);
    read_slot(4'd3, 12'h031, "R3 data slot 3");
  endtask

  task automatic t_seq_chain_wrap();
    reset_dut();
    en_i = 1'b1; mode_i = 2'd1; start_slot_i = 4'd14; chain_i = 1'b1;
    slot_eos_i = 16'h0002;
    pulse_trig();
    for (int n = 0; n < 4; n++) begin
      logic [3:0] s;
      s = 4'(14 + n);
      check("R4 wrap slot", slot_o, s);
      check("R12 channel", chan_o, s ^ 4'd5);
      do_conv(12'(100 + n));
    end
    check("R5 chained run ends", busy_o, 0);
    check("R4 flags", done_flags_o, 16'hC003);
    read_slot(4'd0, 12'd102, "R4 data slot 0");
  endtask

  task automatic t_rep_single();
    reset_dut();
    en_i = 1'b1; mode_i = 2'd2; start_slot_i = 4'd5; chain_i = 1'b1;
    pulse_trig();
    do_conv(12'd1);
    check("R10 repeats slot", slot_o, 5);
    check("R10 busy", busy_o, 1);
    do_conv(12'd2);
    check("R9 ovf on unread rewrite", ovf_o, 1);
    en_i = 1'b0;
    do_conv(12'd3);
    check("R10 stops after en low", busy_o, 0);
    read_slot(4'd5, 12'd3, "R10 last data");
    check("R9 ovf sticky", ovf_o, 1);
  endtask

  task automatic t_rep_seq();
    reset_dut();
    en_i = 1'b1; mode_i = 2'd3; start_slot_i = 4'd6; chain_i = 1'b1;
    slot_eos_i = 16'h0080;
    pulse_trig();
    do_conv(12'd10);
    check("R11 second slot", slot_o, 7);
    do_conv(12'd11);
    check("R11 back to start", slot_o, 6);
    check("R11 busy", busy_o, 1);
    do_conv(12'd12);
    en_i = 1'b0;
    do_conv(12'd13);
    check("R11 stops at end of pass", busy_o, 0);
    read_slot(4'd6, 12'd12, "R11 data slot 6");
    read_slot(4'd7, 12'd13, "R11 data slot 7");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_enable();
        t_single();
        t_seq_trig();
        t_seq_chain_wrap();
        t_rep_single();
        t_rep_seq();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule